// File: doc/BRIEF.md
# Packet-over-SONET HDLC Transmit Encapsulator

This block turns packets from a byte-wide system interface into a continuous HDLC-framed octet stream that a downstream payload-envelope mapper consumes one octet per enabled cycle. Each packet is offered byte by byte with start and end markers. The block can place a configurable address and control octet pair in front of the payload. It can append a 32-bit frame check sequence. It applies octet transparency so that the flag and escape codes never occur inside a frame.

Between packets the block sends flag octets continuously. As a final stage it can scramble the stream with a self-synchronous x^43+1 scrambler. Each of the three options (header insertion, check-sequence generation, scrambling) has its own switch. With check-sequence generation off, a check sequence that the system supplies at the end of its packet passes through as ordinary payload.

The downstream mapper paces the block through `out_en`. When escaping doubles an octet, `in_ready` holds the source off. A source that stops supplying bytes in the middle of a packet causes an abort.

Top module: `hdlc_tx_encap`

## Requirements
- R1: At a clock edge with `rst_n` low, `out_data` becomes 0x7E, the scrambler state clears to zero and framing returns to idle. In idle with `in_valid` low, `in_ready` is low.
- R2: The block produces exactly one octet on `out_data` at each rising edge where `out_en` is high. While `out_en` is low, `out_data` holds and `in_ready` is low.
- R3: In idle every produced octet is the flag 0x7E. A byte offered with `in_sop` is not taken in that cycle: the block sends one flag and then opens the frame. Frames offered back to back are separated by exactly one flag.
- R4: With `cfg_hdr_en` high, `cfg_addr` and then `cfg_ctrl` are sent after the opening flag, ahead of the payload.
- R5: With `cfg_fcs_en` high, a 32-bit check sequence follows the payload. It covers the header octets (when inserted) and the payload. It uses polynomial 0x04C11DB7, a preset of all ones and data bits taken least significant first, and the result is complemented. Its least significant octet is sent first, so the payload "123456789" gives 26 39 F4 CB.
- R6: With `cfg_fcs_en` low, nothing is appended: the frame ends with the last payload byte, and payload bytes are sent unchanged apart from escaping.
- R7: Any in-frame octet (header, payload or check sequence) equal to 0x7E or 0x7D is sent as 0x7D followed by that octet XOR 0x20. `in_ready` stays low while the second octet is sent.
- R8: With `cfg_scr_en` high, each octet is scrambled most significant bit first. Each output bit is the input bit XOR the output bit produced 43 bits earlier. The 43-bit state is carried across flags and frames.
- R9: With `cfg_scr_en` low, `out_data` is the unscrambled octet and the scrambler state is held unchanged.
- R10: If `in_valid` is low when a payload byte is due, the block sends 0x7D followed by a flag (abort) and returns to idle.
- R11: In idle, a byte offered without `in_sop` is accepted at once (`in_ready` high when `out_en` is high) and discarded, so the tail of an aborted packet never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hdr_en | input | 1 | Insert address and control octets |
| cfg_fcs_en | input | 1 | Generate and append the 32-bit check sequence |
| cfg_scr_en | input | 1 | Enable the x^43+1 output scrambler |
| cfg_addr | input | 8 | Address octet to insert (commonly 0xFF) |
| cfg_ctrl | input | 8 | Control octet to insert (commonly 0x03) |
| in_valid | input | 1 | Source byte available |
| in_data | input | 8 | Source byte |
| in_sop | input | 1 | Byte is first of a packet |
| in_eop | input | 1 | Byte is last of a packet |
| in_ready | output | 1 | Byte taken at this edge when `in_valid` is also high |
| out_en | input | 1 | Produce one output octet at this edge |
| out_data | output | 8 | Framed, optionally scrambled octet |

## Verification
The bench builds the block with its default 43-bit scrambler and 8-bit octets. At that size every single-octet payload value 0x00 to 0xFF can be run through a full frame, and short packets can be run under all eight switch combinations. Header values that themselves need escaping are included. A bench-side descrambler with its own 43-bit history recovers the unscrambled stream. This lets one framing comparison cover scrambled and bypassed runs alike, and it shows that the scrambler state carries across changes of the scrambling switch. A fixed "123456789" frame ties the check-sequence arithmetic to a known value.

// File: rtl/hdlc_pkg.sv
// Shared constants, frame state type and check-sequence arithmetic for the
// HDLC transmit encapsulator. Assumes 8-bit octets throughout.
package hdlc_pkg;
    localparam int OCT_W    = 8;
    localparam int FCS_W    = 32;
    localparam int FCS_OCTS = FCS_W / OCT_W;

    localparam logic [OCT_W-1:0] FLAG_OCT = 8'h7E;
    localparam logic [OCT_W-1:0] ESC_OCT  = 8'h7D;
    localparam logic [OCT_W-1:0] ESC_MASK = 8'h20;

    // Reflected form of polynomial 0x04C11DB7 for LSB-first processing.
    localparam logic [FCS_W-1:0] FCS_PRESET    = '1;
    localparam logic [FCS_W-1:0] FCS_POLY_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_ADDR,
        ST_CTRL,
        ST_BODY,
        ST_FCS
    } frm_state_t;

    // Advance the check register by one octet, least significant bit first.
    function automatic logic [FCS_W-1:0] fcs_next(input logic [FCS_W-1:0] crc,
                                                  input logic [OCT_W-1:0] oct);
        logic [FCS_W-1:0] r;
        r = crc;
        for (int i = 0; i < OCT_W; i++) begin
            if (r[0] ^ oct[i]) r = (r >> 1) ^ FCS_POLY_REFL;
            else               r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/hdlc_fcs_gen.sv
// Check-sequence register. Preset while the framer is idle, advanced once per
// covered octet, and presented complemented for transmission.
// Assumes init and upd are never both requested for the same edge.
module hdlc_fcs_gen
    import hdlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic [OCT_W-1:0] oct,
    output logic [FCS_W-1:0] fcs_word
);
    logic [FCS_W-1:0] crc_q;

    // Purpose: hold the running remainder over header and payload octets.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= FCS_PRESET;
        else if (init) crc_q <= FCS_PRESET;
        else if (upd)  crc_q <= fcs_next(crc_q, oct);
    end

    assign fcs_word = ~crc_q;
endmodule

// File: rtl/hdlc_stuffer.sv
// Octet transparency stage. A candidate marked for stuffing that equals the
// flag or escape code is replaced by the escape code, and the masked original
// is held for the next step. While it is held, no new candidate is taken.
// Assumes the requester keeps its candidate stable until it is taken.
module hdlc_stuffer
    import hdlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [OCT_W-1:0] cand,
    input  logic             cand_stuff,
    output logic [OCT_W-1:0] oct,
    output logic             taken,
    output logic             busy
);
    logic             busy_q;
    logic [OCT_W-1:0] held_q;
    logic             special;

    assign special = cand_stuff && ((cand == FLAG_OCT) || (cand == ESC_OCT));
    assign busy    = busy_q;

    // Purpose: choose the octet for this step and say whether the candidate went.
    always_comb begin
        if (busy_q) begin
            oct   = held_q;
            taken = 1'b0;
        end else begin
            oct   = special ? ESC_OCT : cand;
            taken = 1'b1;
        end
    end

    // Purpose: remember the masked octet owed after an escape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            held_q <= '0;
        end else if (step) begin
            if (busy_q) begin
                busy_q <= 1'b0;
            end else if (special) begin
                busy_q <= 1'b1;
                held_q <= cand ^ ESC_MASK;
            end
        end
    end
endmodule

// File: rtl/hdlc_scrambler.sv
// Self-synchronous x^LEN+1 scrambler over one octet per step, MSB first.
// When disabled the octet passes through and the state is held.
module hdlc_scrambler
    import hdlc_pkg::*;
#(
    parameter int SCR_LEN = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             en,
    input  logic [OCT_W-1:0] din,
    output logic [OCT_W-1:0] dout
);
    logic [SCR_LEN-1:0] state_q;
    logic [SCR_LEN-1:0] state_nx;
    logic [OCT_W-1:0]   scr_oct;

    // Purpose: scramble the octet bit by bit against the output history.
    always_comb begin
        state_nx = state_q;
        scr_oct  = '0;
        for (int i = OCT_W - 1; i >= 0; i--) begin
            scr_oct[i] = din[i] ^ state_nx[SCR_LEN-1];
            state_nx   = {state_nx[SCR_LEN-2:0], scr_oct[i]};
        end
    end

    assign dout = en ? scr_oct : din;

    // Purpose: keep the last SCR_LEN scrambled bits across all octets.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= '0;
        else if (step && en) state_q <= state_nx;
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
// Frame sequencer: idle flags, optional header, payload, optional check
// sequence, with escaping applied through the stuffer and underrun abort.
// Assumes a packet's bytes arrive back to back while in_ready is offered.
module hdlc_tx_framer
    import hdlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cfg_hdr_en,
    input  logic             cfg_fcs_en,
    input  logic [OCT_W-1:0] cfg_addr,
    input  logic [OCT_W-1:0] cfg_ctrl,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    output logic [OCT_W-1:0] raw_oct,
    output logic             fill,
    output logic             esc_busy
);
    localparam int IDX_W = $clog2(FCS_OCTS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_OCTS - 1);

    frm_state_t       state_q, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic [OCT_W-1:0] cand;
    logic             cand_stuff;
    logic             taken;
    logic             go;
    logic             crc_init;
    logic             crc_upd;
    logic [FCS_W-1:0] fcs_word;

    assign go   = step && taken;
    assign fill = (state_q == ST_FILL);

    hdlc_stuffer u_stuff (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .cand       (cand),
        .cand_stuff (cand_stuff),
        .oct        (raw_oct),
        .taken      (taken),
        .busy       (esc_busy)
    );

    hdlc_fcs_gen u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (crc_init),
        .upd      (crc_upd),
        .oct      (cand),
        .fcs_word (fcs_word)
    );

    // Purpose: pick the candidate octet, the handshake and the next state.
    always_comb begin
        state_nx   = state_q;
        cand       = FLAG_OCT;
        cand_stuff = 1'b0;
        in_ready   = 1'b0;
        crc_init   = 1'b0;
        crc_upd    = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                crc_init = 1'b1;
                in_ready = go && in_valid && !in_sop;
                if (go && in_valid && in_sop)
                    state_nx = cfg_hdr_en ? ST_ADDR : ST_BODY;
            end
            ST_ADDR: begin
                cand       = cfg_addr;
                cand_stuff = 1'b1;
                crc_upd    = go;
                if (go) state_nx = ST_CTRL;
            end
            ST_CTRL: begin
                cand       = cfg_ctrl;
                cand_stuff = 1'b1;
                crc_upd    = go;
                if (go) state_nx = ST_BODY;
            end
            ST_BODY: begin
                if (!in_valid) begin
                    cand = ESC_OCT;
                    if (go) state_nx = ST_FILL;
                end else begin
                    cand       = in_data;
                    cand_stuff = 1'b1;
                    in_ready   = go;
                    crc_upd    = go;
                    if (go && in_eop)
                        state_nx = cfg_fcs_en ? ST_FCS : ST_FILL;
                end
            end
            ST_FCS: begin
                cand       = fcs_word[idx_q*OCT_W +: OCT_W];
                cand_stuff = 1'b1;
                if (go && (idx_q == IDX_LAST)) state_nx = ST_FILL;
            end
            default: state_nx = ST_FILL;
        endcase
    end

    // Purpose: register the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else if (step) state_q <= state_nx;
    end

    // Purpose: count check-sequence octets, least significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q != ST_FCS) begin
            idx_q <= '0;
        end else if (go) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_tx_encap.sv
// Top of the HDLC transmit encapsulator: framer, optional x^SCR_LEN+1
// scrambler and the registered output octet. One octet leaves at each edge
// with out_en high. Configuration inputs are assumed static during a frame.
module hdlc_tx_encap
    import hdlc_pkg::*;
#(
    parameter int SCR_LEN = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hdr_en,
    input  logic             cfg_fcs_en,
    input  logic             cfg_scr_en,
    input  logic [OCT_W-1:0] cfg_addr,
    input  logic [OCT_W-1:0] cfg_ctrl,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    input  logic             out_en,
    output logic [OCT_W-1:0] out_data
);
    logic [OCT_W-1:0] raw_oct;
    logic [OCT_W-1:0] line_oct;
    logic             fill;
    logic             esc_busy;

    hdlc_tx_framer u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (out_en),
        .cfg_hdr_en (cfg_hdr_en),
        .cfg_fcs_en (cfg_fcs_en),
        .cfg_addr   (cfg_addr),
        .cfg_ctrl   (cfg_ctrl),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_ready   (in_ready),
        .raw_oct    (raw_oct),
        .fill       (fill),
        .esc_busy   (esc_busy)
    );

    hdlc_scrambler #(.SCR_LEN(SCR_LEN)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (out_en),
        .en    (cfg_scr_en),
        .din   (raw_oct),
        .dout  (line_oct)
    );

    // Purpose: register the line octet once per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= FLAG_OCT;
        else if (out_en) out_data <= line_oct;
    end
endmodule

// File: rtl/hdlc_tx_encap_chk.sv
// Property checker for the HDLC transmit encapsulator, bound to the top.
// Watches the handshake, the output hold, escaping and scrambler bypass.
module hdlc_tx_encap_chk
    import hdlc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             out_en,
    input logic [OCT_W-1:0] out_data,
    input logic             in_ready,
    input logic             cfg_scr_en,
    input logic [OCT_W-1:0] raw_oct,
    input logic             fill,
    input logic             esc_busy
);
    // R2: output octet holds while not enabled
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(out_data));

    // R2: a byte is only taken on an enabled cycle
    a_r2_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_en);

    // R7: no flag code leaves the framer while inside a frame
    a_r7_no_flag_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !fill) |-> (raw_oct != FLAG_OCT));

    // R7: source held off while the masked octet is owed
    a_r7_hold_during_escape: assert property (@(posedge clk) disable iff (!rst_n)
        esc_busy |-> !in_ready);

    // R9: bypassed scrambler passes the framed octet straight to the output
    a_r9_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_scr_en && out_en) |=> (out_data == $past(raw_oct)));
endmodule

bind hdlc_tx_encap hdlc_tx_encap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_en     (out_en),
    .out_data   (out_data),
    .in_ready   (in_ready),
    .cfg_scr_en (cfg_scr_en),
    .raw_oct    (raw_oct),
    .fill       (fill),
    .esc_busy   (esc_busy)
);

// File: tb/sim_hdlc_tx_encap.sv
// Self-checking bench for hdlc_tx_encap: descrambles the output with its own
// model, rebuilds each expected frame arithmetically and compares streams.
module sim_hdlc_tx_encap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_hdr_en = 1'b0, cfg_fcs_en = 1'b1, cfg_scr_en = 1'b0;
    logic [7:0] cfg_addr = 8'hFF, cfg_ctrl = 8'h03;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_en = 1'b1;
    logic [7:0] out_data;

    always #5 clk = ~clk;

    hdlc_tx_encap u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hdr_en(cfg_hdr_en), .cfg_fcs_en(cfg_fcs_en),
        .cfg_scr_en(cfg_scr_en), .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_ready(in_ready), .out_en(out_en), .out_data(out_data)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Enable pacing: forced level, or a 2-of-3 pattern in gated mode.
    bit gate_mode = 1'b0;
    bit en_force = 1'b1;
    int gcnt = 0;
    always @(negedge clk) begin
        gcnt   <= gcnt + 1;
        out_en <= gate_mode ? (gcnt % 3 != 0) : en_force;
    end

    // Collector: one captured octet per enabled edge, descrambled when needed.
    logic        en_q = 1'b0, scr_q = 1'b0;
    logic [42:0] dh = '0;
    logic [7:0]  cx, cd;
    byte unsigned cap[$];
    int raw_diff = 0;

    always @(posedge clk) begin
        en_q  <= out_en && rst_n;
        scr_q <= cfg_scr_en;
    end

    always @(negedge clk) begin
        if (en_q) begin
            cx = out_data;
            if (scr_q) begin
                for (int i = 7; i >= 0; i--) begin
                    cd[i] = cx[i] ^ dh[42];
                    dh    = {dh[41:0], cx[i]};
                end
                if (cx != 8'h7E) raw_diff++;
            end else begin
                cd = cx;
            end
            cap.push_back(cd);
        end
    end

    // Reference check sequence: MSB-first register on bit-reversed input.
    function automatic logic [31:0] ref_fcs(input byte unsigned m[$]);
        logic [31:0] c, r;
        logic fb;
        c = 32'hFFFFFFFF;
        foreach (m[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ m[k][i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        c = ~c;
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return r;
    endfunction

    function automatic void put(ref byte unsigned q[$], input byte unsigned b);
        if (b == 8'h7E || b == 8'h7D) begin
            q.push_back(8'h7D);
            q.push_back(b ^ 8'h20);
        end else begin
            q.push_back(b);
        end
    endfunction

    task automatic build(input bit hdr, input bit fcs, input byte unsigned pay[$],
                         ref byte unsigned e[$]);
        byte unsigned cov[$];
        logic [31:0] f;
        if (hdr) begin
            cov.push_back(cfg_addr);
            cov.push_back(cfg_ctrl);
        end
        foreach (pay[k]) cov.push_back(pay[k]);
        foreach (cov[k]) put(e, cov[k]);
        if (fcs) begin
            f = ref_fcs(cov);
            for (int k = 0; k < 4; k++) put(e, f[8*k +: 8]);
        end
    endtask

    // Offer one byte from a falling edge until an edge takes it.
    task automatic push(input byte unsigned b, input bit s, input bit e);
        bit r;
        in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
        do begin
            #4 r = in_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!r);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send(input byte unsigned pay[$]);
        foreach (pay[k]) push(pay[k], k == 0, k == pay.size() - 1);
    endtask

    // Leading flags, then exactly the expected octets, then only flags (one or more).
    task automatic check_stream(input string req, input byte unsigned e[$]);
        int i = 0;
        int tail = 0;
        bit ok = 1'b1;
        longint a = 0, x = 0;
        while (i < cap.size() && cap[i] == 8'h7E) i++;
        foreach (e[k]) begin
            if (ok && (i + k >= cap.size() || cap[i+k] != e[k])) begin
                ok = 1'b0;
                a  = (i + k < cap.size()) ? cap[i+k] : -1;
                x  = e[k];
            end
        end
        i += e.size();
        if (ok) begin
            while (i < cap.size()) begin
                if (cap[i] != 8'h7E && ok) begin ok = 1'b0; a = cap[i]; x = 8'h7E; end
                tail++;
                i++;
            end
            if (ok && tail < 1) begin ok = 1'b0; a = tail; x = 1; end
        end
        chk(ok, req, "framed stream", a, x);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_main();
        byte unsigned pay[$];
        byte unsigned e[$];
        byte unsigned e2[$];
        logic [7:0] hold_v;
        bit all_flag;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_data == 8'h7E, "R1", "out_data in reset", out_data, 8'h7E);
        #4 chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        #4 chk(in_ready == 1'b0, "R1", "in_ready idle", in_ready, 0);

        // R3: idle fill, one octet per enabled edge (R2)
        @(negedge clk);
        cap.delete();
        settle(12);
        all_flag = 1'b1;
        foreach (cap[k]) if (cap[k] != 8'h7E) all_flag = 1'b0;
        chk(all_flag, "R3", "idle flags", all_flag, 1);
        chk(cap.size() >= 11, "R2", "octet count", cap.size(), 12);

        // R5: fixed vector "123456789"
        cfg_hdr_en = 1'b0; cfg_fcs_en = 1'b1; cfg_scr_en = 1'b0;
        cap.delete();
        pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send(pay);
        settle(12);
        e = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
              8'h26, 8'h39, 8'hF4, 8'hCB};
        check_stream("R5", e);

        // R6: external check sequence passes unchanged apart from escaping
        cfg_fcs_en = 1'b0;
        cap.delete();
        pay = '{8'hA1, 8'h7E, 8'hB2};
        send(pay);
        settle(8);
        e = '{8'hA1, 8'h7D, 8'h5E, 8'hB2};
        check_stream("R6", e);

        // R4 R5 R6 R8 R9: all switch combinations, short packets, escaped headers
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int len = 1; len <= 5; len++) begin
                cfg_hdr_en = cfg[0]; cfg_fcs_en = cfg[1]; cfg_scr_en = cfg[2];
                cfg_addr   = (len % 2 == 0) ? 8'h7E : 8'hFF;
                cfg_ctrl   = (len == 3) ? 8'h7D : 8'h03;
                pay.delete();
                for (int k = 0; k < len; k++)
                    pay.push_back((k == 1) ? 8'h7D - 8'(cfg % 2) : 8'((k*53 + len*7 + cfg*11) & 255));
                e.delete();
                build(cfg[0], cfg[1], pay, e);
                settle(2);
                cap.delete();
                send(pay);
                settle(25);
                check_stream($sformatf("%s/%s/%s", cfg[0] ? "R4" : "R3",
                             cfg[1] ? "R5" : "R6", cfg[2] ? "R8" : "R9"), e);
            end
        end

        // R7: every single-octet payload value, header and check sequence on, scrambled
        cfg_hdr_en = 1'b1; cfg_fcs_en = 1'b1; cfg_scr_en = 1'b1;
        cfg_addr = 8'hFF; cfg_ctrl = 8'h03;
        for (int v = 0; v < 256; v++) begin
            pay = '{8'(v)};
            e.delete();
            build(1'b1, 1'b1, pay, e);
            cap.delete();
            send(pay);
            settle(16);
            check_stream("R7", e);
        end
        chk(raw_diff > 0, "R8", "scrambled line differs from flags", raw_diff, 1);

        // R3: back-to-back frames share exactly one flag
        cfg_scr_en = 1'b0;
        settle(2);
        cap.delete();
        pay = '{8'h01, 8'h02};
        e.delete();
        build(1'b1, 1'b1, pay, e);
        send(pay);
        pay = '{8'h03};
        e2.delete();
        build(1'b1, 1'b1, pay, e2);
        send(pay);
        settle(20);
        e.push_back(8'h7E);
        foreach (e2[k]) e.push_back(e2[k]);
        check_stream("R3", e);

        // R10: underrun aborts; R11: the rest of the packet is dropped
        cfg_hdr_en = 1'b0;
        cap.delete();
        push(8'h11, 1'b1, 1'b0);
        push(8'h7E, 1'b0, 1'b0);
        settle(3);
        push(8'h22, 1'b0, 1'b0);
        push(8'h33, 1'b0, 1'b1);
        settle(10);
        e = '{8'h11, 8'h7D, 8'h5E, 8'h7D};
        check_stream("R10", e);
        in_valid = 1'b1; in_data = 8'h44; in_sop = 1'b0;
        #4 chk(in_ready == 1'b1, "R11", "stray byte accepted", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        cap.delete();
        settle(6);
        all_flag = 1'b1;
        foreach (cap[k]) if (cap[k] != 8'h7E) all_flag = 1'b0;
        chk(all_flag, "R11", "stray byte not sent", all_flag, 1);

        // R2: gated enable, stream unchanged
        cfg_hdr_en = 1'b1; cfg_scr_en = 1'b1;
        gate_mode = 1'b1;
        settle(2);
        cap.delete();
        pay = '{8'h7D, 8'h10, 8'h7E};
        e.delete();
        build(1'b1, 1'b1, pay, e);
        send(pay);
        settle(40);
        check_stream("R2", e);
        gate_mode = 1'b0;

        // R2: hold while disabled
        en_force = 1'b0;
        settle(2);
        hold_v = out_data;
        in_valid = 1'b1; in_data = 8'h55; in_sop = 1'b0;
        #4 chk(in_ready == 1'b0, "R2", "in_ready while disabled", in_ready, 0);
        settle(3);
        chk(out_data == hold_v, "R2", "out_data held", out_data, hold_v);
        in_valid = 1'b0;
        en_force = 1'b1;
        settle(3);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule